// File: doc/BRIEF.md
# GF(2^128) Streaming Multiply-Reduce Unit

This unit multiplies pairs of elements of the binary field GF(2^128) and returns one reduced 128-bit product for each pair. Operands arrive as a stream on a valid/ready input channel, and each pair carries a tag. The tag leaves with the matching result, so a consumer working through a batch can confirm that the results come back in order.

The datapath has two steps. First, a carryless (XOR-accumulate) multiplier forms the 256-bit polynomial product. Second, a shift/XOR network folds that product modulo x^128 + x^7 + x^2 + x + 1. The fold works in two passes:

- The upper half H is combined with its own top bits, shifted down by 127, 126 and 121, to give T.
- T is added to the lower half L together with copies of T shifted left by 1, 2 and 7.

Both passes are registered stages of a two-deep pipeline. Each stage has its own valid/ready hand-off, so backpressure on the output holds results in place and is never lost. Field elements use the polynomial basis: bit i of a 128-bit word is the coefficient of x^i. Field addition is bitwise XOR.

Top module: `gf128_mulred_stream`

## Requirements
- R1: For every accepted pair (a, b), the result equals a·b reduced modulo x^128 + x^7 + x^2 + x + 1. Bit i of each operand and of the result is the coefficient of x^i. This holds for operands with top bits set, such as x^127·x^127 and all-ones times all-ones.
- R2: Multiplying by the element 1 (value 128'h1, bit 0 set) returns the other operand unchanged, whichever side the 1 is on.
- R3: Multiplying by the element 0 returns 0, whichever side the 0 is on.
- R4: Results leave in the order their inputs were accepted. Each result carries the tag presented with its input.
- R5: While out_ready stays high, a pair accepted at a clock edge appears on out_valid/out_data two edges later.
- R6: While out_valid is high and out_ready is low, out_valid, out_data and out_tag hold their values at the next edge.
- R7: Every accepted input yields exactly one output, with no drops and no duplicates. The unit holds at most two pairs in flight, and out_valid is low when none are in flight.
- R8: After a clock edge with rst high, out_valid is low.
- R9: While out_ready is high, in_ready is high, so one pair can be accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Unit can take a pair this cycle |
| in_a | input | 128 | First operand, bit i is the coefficient of x^i |
| in_b | input | 128 | Second operand, bit i is the coefficient of x^i |
| in_tag | input | TAG_W | Tag travelling with the pair |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Reduced field product |
| out_tag | output | TAG_W | Tag of the pair this result belongs to |

## Verification
The assertions take for granted that the source obeys the input handshake. Once in_valid is raised with a pair, it stays raised with that pair until in_ready accepts it. Only under this condition does the occupancy count kept by the checker match what the unit holds. The bench keeps to this rule: it changes in_a, in_b and in_tag only on a falling edge after an accepting rising edge. It varies out_ready freely, including random stall patterns, because the output side places no constraint on the consumer.

// File: rtl/gf128_pkg.sv
package gf128_pkg;

    localparam int FIELD_W = 128;
    localparam int PROD_W  = 2 * FIELD_W;
    localparam int LOW_W   = 8;
    localparam logic [LOW_W-1:0] POLY_LOW = 8'h87;

    typedef struct packed {
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] lo;
    } gfm_wide_t;

    function automatic gfm_wide_t gfm_clmul(input logic [FIELD_W-1:0] a,
                                            input logic [FIELD_W-1:0] b);
        logic [PROD_W-1:0] acc;
        logic [PROD_W-1:0] ax;
        acc = '0;
        ax  = {{FIELD_W{1'b0}}, a};
        for (int i = 0; i < FIELD_W; i++) begin
            if (b[i]) acc = acc ^ ax;
            ax = ax << 1;
        end
        return gfm_wide_t'(acc);
    endfunction

endpackage

// File: rtl/gfm_clmul.sv
module gfm_clmul
    import gf128_pkg::*;
(
    input  logic [FIELD_W-1:0] op_x,
    input  logic [FIELD_W-1:0] op_y,
    output gfm_wide_t          prod
);
    always_comb prod = gfm_clmul(op_x, op_y);
endmodule

// File: rtl/gfm_fold.sv
module gfm_fold
    import gf128_pkg::*;
#(
    parameter logic [LOW_W-1:0] LOW = POLY_LOW
) (
    input  gfm_wide_t          prod,
    output logic [FIELD_W-1:0] res
);
    logic [FIELD_W-1:0] spill [LOW_W];
    logic [FIELD_W-1:0] taps  [LOW_W];
    logic [FIELD_W-1:0] t;

    // first pass: bits pushed past x^127 by each low tap come back down
    // second pass: the folded upper half is spread over the low taps
    for (genvar k = 0; k < LOW_W; k++) begin : g_tap
        if (k == 0) begin : g_zero
            assign spill[k] = '0;
            assign taps[k]  = LOW[0] ? t : '0;
        end else begin : g_pos
            assign spill[k] = LOW[k] ? (prod.hi >> (FIELD_W - k)) : '0;
            assign taps[k]  = LOW[k] ? (t << k) : '0;
        end
    end

    always_comb begin
        t = prod.hi;
        for (int k = 0; k < LOW_W; k++) t = t ^ spill[k];
    end

    always_comb begin
        res = prod.lo;
        for (int k = 0; k < LOW_W; k++) res = res ^ taps[k];
    end
endmodule

// File: rtl/gfm_stage.sv
module gfm_stage #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic [PW-1:0] up_data,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic [PW-1:0] dn_data
);
    assign up_ready = !dn_valid || dn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_valid <= 1'b0;
        end else if (up_ready) begin
            dn_valid <= up_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (up_valid && up_ready) dn_data <= up_data;
    end
endmodule

// File: rtl/gf128_mulred_stream.sv
module gf128_mulred_stream
    import gf128_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [FIELD_W-1:0] in_a,
    input  logic [FIELD_W-1:0] in_b,
    input  logic [TAG_W-1:0]   in_tag,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [FIELD_W-1:0] out_data,
    output logic [TAG_W-1:0]   out_tag
);
    localparam int S1_W = PROD_W + TAG_W;
    localparam int S2_W = FIELD_W + TAG_W;

    gfm_wide_t          prod_c;
    logic [S1_W-1:0]    s1_q;
    logic               s1_valid;
    logic               s1_ready;
    gfm_wide_t          s1_prod;
    logic [TAG_W-1:0]   s1_tag;
    logic [FIELD_W-1:0] red_c;
    logic [S2_W-1:0]    s2_q;

    gfm_clmul u_mul (
        .op_x (in_a),
        .op_y (in_b),
        .prod (prod_c)
    );

    gfm_stage #(.PW(S1_W)) u_s1 (
        .clk      (clk),
        .rst      (rst),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  ({prod_c, in_tag}),
        .dn_valid (s1_valid),
        .dn_ready (s1_ready),
        .dn_data  (s1_q)
    );

    assign s1_prod = gfm_wide_t'(s1_q[S1_W-1:TAG_W]);
    assign s1_tag  = s1_q[TAG_W-1:0];

    gfm_fold #(.LOW(POLY_LOW)) u_fold (
        .prod (s1_prod),
        .res  (red_c)
    );

    gfm_stage #(.PW(S2_W)) u_s2 (
        .clk      (clk),
        .rst      (rst),
        .up_valid (s1_valid),
        .up_ready (s1_ready),
        .up_data  ({red_c, s1_tag}),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (s2_q)
    );

    assign out_data = s2_q[S2_W-1:TAG_W];
    assign out_tag  = s2_q[TAG_W-1:0];
endmodule

// File: rtl/gfm_checker.sv
module gfm_checker #(
    parameter int TAG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [127:0]     out_data,
    input logic [TAG_W-1:0] out_tag
);
    logic [2:0] occ;
    logic       fire_in;
    logic       fire_out;

    assign fire_in  = in_valid && in_ready;
    assign fire_out = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) occ <= '0;
        else     occ <= occ + 3'(fire_in) - 3'(fire_out);
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_tag));

    p_occ_max_r7: assert property (@(posedge clk) disable iff (rst)
        occ <= 3'd2);

    p_empty_r7: assert property (@(posedge clk) disable iff (rst)
        occ == 3'd0 |-> !out_valid);

    p_reset_r8: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

    p_rate_r9: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready);
endmodule

bind gf128_mulred_stream gfm_checker #(.TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_tag   (out_tag)
);

// File: tb/sim_gf128_mulred_stream.sv
`timescale 1ns/1ps
module sim_gf128_mulred_stream;
    localparam int TW = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [127:0]   in_a = '0;
    logic [127:0]   in_b = '0;
    logic [TW-1:0]  in_tag = '0;
    logic           out_valid;
    logic           out_ready = 1'b1;
    logic [127:0]   out_data;
    logic [TW-1:0]  out_tag;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int lows    = 0;
    int n_in    = 0;
    int n_out   = 0;
    bit bp_mode = 1'b0;
    int kind_now = 1;
    logic [TW-1:0] tag_ctr = '0;

    typedef struct {
        logic [127:0]  exp;
        logic [TW-1:0] tag;
        int            cyc;
        int            lows;
        int            kind;
    } exp_t;
    exp_t q[$];

    bit           was_stalled = 1'b0;
    logic [127:0] held_data;
    logic [TW-1:0] held_tag;

    always #10 clk = ~clk;

    gf128_mulred_stream #(.TAG_W(TW)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_tag(out_tag)
    );

    // shift-and-add product, reducing as soon as x^128 appears
    function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
        logic [128:0] aa;
        logic [127:0] r;
        aa = {1'b0, a};
        r  = '0;
        for (int i = 0; i < 128; i++) begin
            if (b[i]) r = r ^ aa[127:0];
            aa = aa << 1;
            if (aa[128]) aa = {1'b0, aa[127:0] ^ 128'h87};
        end
        return r;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // consumer side
    always @(negedge clk) begin
        if (bp_mode) out_ready <= ($urandom % 3) != 0;
        else         out_ready <= 1'b1;
    end

    // monitor and scoreboard
    always @(negedge clk) begin
        #2;
        cyc++;
        if (cyc > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not complete, cycle %0d expected below 150000", cyc);
            finish_up();
        end
        if (!rst) begin
            if (!out_ready) lows++;
            if (was_stalled) begin
                n_tests++;
                if (!out_valid || out_data !== held_data || out_tag !== held_tag) begin
                    n_fail++;
                    $display("FAIL R6 hold: valid=%0b data=%h tag=%h expected valid=1 data=%h tag=%h",
                             out_valid, out_data, out_tag, held_data, held_tag);
                end
            end
            if (out_ready && !in_ready) begin
                n_tests++; n_fail++;
                $display("FAIL R9: in_ready=0 expected 1 while out_ready=1");
            end
            if (out_valid && out_ready) begin
                exp_t e;
                n_out++;
                n_tests++;
                if (q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R7: extra output data=%h tag=%h expected none", out_data, out_tag);
                end else begin
                    e = q.pop_front();
                    if (out_data !== e.exp || out_tag !== e.tag) begin
                        n_fail++;
                        $display("FAIL %s/R4: data=%h tag=%h expected data=%h tag=%h",
                                 e.kind == 2 ? "R2" : (e.kind == 3 ? "R3" : "R1"),
                                 out_data, out_tag, e.exp, e.tag);
                    end
                    if (e.lows == lows) begin
                        n_tests++;
                        if (cyc - e.cyc != 2) begin
                            n_fail++;
                            $display("FAIL R5 latency: %0d expected 2", cyc - e.cyc);
                        end
                    end
                end
            end
            was_stalled = out_valid && !out_ready;
            held_data = out_data;
            held_tag  = out_tag;
            if (in_valid && in_ready) begin
                exp_t e;
                e.exp = ref_mul(in_a, in_b);
                e.tag = in_tag;
                e.cyc = cyc;
                e.lows = lows;
                e.kind = kind_now;
                q.push_back(e);
                n_in++;
            end
        end
    end

    task automatic send(input logic [127:0] a, input logic [127:0] b, input int kind);
        in_a = a; in_b = b; in_tag = tag_ctr; in_valid = 1'b1; kind_now = kind;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        tag_ctr++;
    endtask

    task automatic drain();
        bp_mode = 1'b0;
        for (int i = 0; i < 50 && q.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        n_tests++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R8: out_valid=%b expected 0 in reset", out_valid);
        end
        rst = 1'b0;
        @(negedge clk);

        // R2: identity on both sides
        for (int i = 0; i < 4; i++) begin
            logic [127:0] v = rnd128();
            send(128'h1, v, 2);
            send(v, 128'h1, 2);
        end
        // R3: zero on both sides
        send(128'h0, rnd128(), 3);
        send({128{1'b1}}, 128'h0, 3);
        // R1: top-bit corners
        send(128'h1 << 127, 128'h1 << 127, 1);
        send({128{1'b1}}, {128{1'b1}}, 1);
        send(128'h1 << 127, 128'h2, 1);
        send(128'h87, 128'h1 << 120, 1);
        drain();

        // R1/R4/R5/R9: back-to-back random stream, no backpressure
        for (int i = 0; i < 40; i++) send(rnd128(), rnd128(), 1);
        drain();

        // R6/R7: random backpressure with bursty input
        bp_mode = 1'b1;
        for (int i = 0; i < 120; i++) begin
            if (($urandom % 4) == 0) @(negedge clk);
            send(rnd128(), rnd128(), 1);
        end
        send(128'h1, 128'hDEADBEEF, 2);
        send(128'h0, 128'hDEADBEEF, 3);
        drain();

        // R7: every accepted input produced exactly one output
        n_tests++;
        if (n_in != n_out || q.size() != 0) begin
            n_fail++;
            $display("FAIL R7: outputs=%0d expected %0d (left in queue %0d)", n_out, n_in, q.size());
        end

        // R8: reset mid-stream clears out_valid
        out_ready = 1'b0;
        send(rnd128(), rnd128(), 1);
        rst = 1'b1;
        @(negedge clk);
        #3;
        n_tests++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R8: out_valid=%b expected 0 after reset", out_valid);
        end
        finish_up();
    end
endmodule